// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects up to 64 interrupt sources and presents them to a processor as two request lines: a fast line and a normal line. Every source owns a latched pending flag, an enable bit and a 3-bit priority. The priority does two jobs. It decides which line the source drives, and it ranks the source against the others when the controller picks a single winner. Software reaches everything through a simple word-addressed register bus. Writes take effect at the next clock edge and read data is returned in the same cycle.

Sources are either edge or level type, chosen per source by a build parameter. An edge source latches its flag on a rising input. A level source sets its flag on every cycle its input is high. Software clears a flag by writing a 1 to it. Masking a source through its enable bit hides it from the outputs, but the flag is kept. The controller also reports the winning source as an entry address, formed as a programmable base plus four times the winner's number. A dispatcher can use that address directly to jump to its handler. No vector table is fetched.

Top module: `prio_intc`

## Requirements
- R1: After reset the following values hold. Enables, flags, control and base read 0. Every priority register reads 0x77777777. Both request lines are low and the entry register reads 0.
- R2: An edge source (default: sources 0 to 31) sets its flag on a rising input. An input that is held high does not set the flag again after it is cleared.
- R3: A level source (default: sources 32 to 63) sets its flag in every cycle its input is high. A clear therefore has no lasting effect while the input stays high. Once the input is low, a clear leaves the flag at 0.
- R4: Writing a 1 to a bit of either status register of a bank clears that source's flag. Writing a 0 leaves the flag unchanged.
- R5: The fast status words sit at 0x00 (sources 0 to 31) and 0x04 (32 to 63). They show the flags of sources with priority 0 or 1. The normal status words sit at 0x08 and 0x0C and show the flags of sources with priority 2 to 7. Within a word, the bit is the source number modulo 32.
- R6: The enable words sit at 0x18 (sources 0 to 31) and 0x1C (32 to 63). A disabled source does not reach the request lines or the entry register. Its flag still reads back in its status word, and it takes part again as soon as it is re-enabled.
- R7: The priority words sit at 0x30 + 4k. Word k holds source 8k+j in bits 4j+2 to 4j. Bit 4j+3 ignores writes and reads 0.
- R8: The fast line is high exactly when an enabled, pending source has priority 0 or 1. The normal line is high exactly when an enabled, pending source has priority 2 to 7.
- R9: The entry word at 0x28 reads base + 4 × the winning source's number. The winner is the source with the lowest priority value; on a tie, the lower source number wins. The word reads 0 when no source competes.
- R10: Control bit 0 at 0x20 sets which sources compete for the entry word. When it is 0, every enabled pending source competes. When it is 1, only sources routed to the normal line compete. The request lines are not affected.
- R11: The base word at 0x24 is readable and writable over all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset; the block releases it synchronously |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, returned in the same cycle |
| src_in | input | NUM_SRC | Interrupt source inputs, synchronous to clk |
| irq_fast | output | 1 | Fast interrupt request |
| irq_norm | output | 1 | Normal interrupt request |

## Verification
The hardest state to reach is a pending flag whose enable is off while higher-ranked sources come and go. A second hard case is a tie between equal priorities that shows only after the stronger source leaves. The stimulus sets both up on purpose. It raises two equal-priority edge sources together with a stronger level source. It then drops and clears the level source, so the lower-numbered source wins the tie. Finally it toggles that source's enable and reads back both the entry word and the untouched status word. The level source is also cleared while its input is still high, to show that the flag comes back. The control bit is flipped while a fast source and a normal source are both pending, so the entry word moves between them while the request lines stay as they were.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // Word indices (byte address >> 2) of the register map.
  localparam int WORD_FST  = 0;   // fast status, banks 0/1
  localparam int WORD_NRM  = 2;   // normal status, banks 0/1
  localparam int WORD_ENA  = 6;   // enables, banks 0/1
  localparam int WORD_CTL  = 8;   // entry control
  localparam int WORD_BASE = 9;   // entry base
  localparam int WORD_ENT  = 10;  // entry result (read only)
  localparam int WORD_PRI  = 12;  // first priority word
  localparam int SRC_PER_BANK = 32;
  localparam int SRC_PER_PRI  = 8;
  localparam int PRIO_W       = 3;

  typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/intc_pending.sv
module intc_pending #(
  parameter int                 NUM_SRC  = 64,
  parameter logic [NUM_SRC-1:0] EDGE_SEL = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [NUM_SRC-1:0] clr,
  output logic [NUM_SRC-1:0] pend
);
  logic [NUM_SRC-1:0] src_d_q;
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] pend_d;
  logic [NUM_SRC-1:0] set;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (EDGE_SEL[i]) begin : g_edge
      assign set[i] = src_in[i] & ~src_d_q[i];
    end else begin : g_level
      assign set[i] = src_in[i];
    end
  end

  // A new event in the same cycle as a clear wins, so no event is lost.
  always_comb begin
    pend_d = (pend_q & ~clr) | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_d_q <= '0;
      pend_q  <= '0;
    end else begin
      src_d_q <= src_in;
      pend_q  <= pend_d;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int LVLS   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]        req,
  input  prio_t [NUM_SRC-1:0]       prio,
  output logic                      win_valid,
  output logic [IDX_W-1:0]          win_idx,
  output prio_t                     win_prio
);
  // Binary tree: each node keeps the left (lower-numbered) child unless the
  // right one is valid with a strictly lower priority value.
  for (genvar lv = 0; lv <= LVLS; lv++) begin : g_lv
    localparam int W = NUM_SRC >> lv;
    logic [W-1:0]            v;
    prio_t [W-1:0]           p;
    logic [W-1:0][IDX_W-1:0] x;
    if (lv == 0) begin : g_leaf
      assign v = req;
      assign p = prio;
      for (genvar i = 0; i < W; i++) begin : g_i
        assign x[i] = IDX_W'(i);
      end
    end else begin : g_node
      for (genvar k = 0; k < W; k++) begin : g_k
        logic take_l;
        assign take_l = g_lv[lv-1].v[2*k] &&
                        (!g_lv[lv-1].v[2*k+1] ||
                         (g_lv[lv-1].p[2*k] <= g_lv[lv-1].p[2*k+1]));
        assign v[k] = g_lv[lv-1].v[2*k] | g_lv[lv-1].v[2*k+1];
        assign p[k] = take_l ? g_lv[lv-1].p[2*k] : g_lv[lv-1].p[2*k+1];
        assign x[k] = take_l ? g_lv[lv-1].x[2*k] : g_lv[lv-1].x[2*k+1];
      end
    end
  end

  assign win_valid = g_lv[LVLS].v[0];
  assign win_idx   = g_lv[LVLS].x[0];
  assign win_prio  = g_lv[LVLS].p[0];
endmodule

// File: rtl/intc_regbank.sv
module intc_regbank
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 8,
  localparam int NBANK  = NUM_SRC / SRC_PER_BANK,
  localparam int NPRI   = NUM_SRC / SRC_PER_PRI,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_SRC-1:0]   pend,
  input  logic [NUM_SRC-1:0]   fast_rt,
  input  logic                 win_valid,
  input  logic [IDX_W-1:0]     win_idx,
  output logic [NUM_SRC-1:0]   en,
  output prio_t [NUM_SRC-1:0]  prio,
  output logic [NUM_SRC-1:0]   clr,
  output logic                 scope_norm
);
  logic [ADDR_W-3:0]   word;
  logic [NUM_SRC-1:0]  en_q, en_d;
  prio_t [NUM_SRC-1:0] prio_q, prio_d;
  logic                ctl_q, ctl_d;
  logic [31:0]         base_q, base_d;

  assign word = bus_addr[ADDR_W-1:2];

  // Next state of the programmable registers and the clear strobe.
  always_comb begin
    en_d   = en_q;
    prio_d = prio_q;
    ctl_d  = ctl_q;
    base_d = base_q;
    clr    = '0;
    if (bus_we) begin
      for (int b = 0; b < NBANK; b++) begin
        if (int'(word) == WORD_FST + b || int'(word) == WORD_NRM + b)
          clr[b*SRC_PER_BANK +: SRC_PER_BANK] = bus_wdata;
        if (int'(word) == WORD_ENA + b)
          en_d[b*SRC_PER_BANK +: SRC_PER_BANK] = bus_wdata;
      end
      for (int k = 0; k < NPRI; k++) begin
        if (int'(word) == WORD_PRI + k) begin
          for (int j = 0; j < SRC_PER_PRI; j++)
            prio_d[k*SRC_PER_PRI+j] = bus_wdata[4*j +: PRIO_W];
        end
      end
      if (int'(word) == WORD_CTL)  ctl_d  = bus_wdata[0];
      if (int'(word) == WORD_BASE) base_d = bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      prio_q <= {NUM_SRC{prio_t'(3'd7)}};
      ctl_q  <= 1'b0;
      base_q <= '0;
    end else if (bus_we) begin
      en_q   <= en_d;
      prio_q <= prio_d;
      ctl_q  <= ctl_d;
      base_q <= base_d;
    end
  end

  // Read multiplexer.
  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (int'(word) == WORD_FST + b)
        bus_rdata = pend[b*SRC_PER_BANK +: SRC_PER_BANK] & fast_rt[b*SRC_PER_BANK +: SRC_PER_BANK];
      if (int'(word) == WORD_NRM + b)
        bus_rdata = pend[b*SRC_PER_BANK +: SRC_PER_BANK] & ~fast_rt[b*SRC_PER_BANK +: SRC_PER_BANK];
      if (int'(word) == WORD_ENA + b)
        bus_rdata = en_q[b*SRC_PER_BANK +: SRC_PER_BANK];
    end
    for (int k = 0; k < NPRI; k++) begin
      if (int'(word) == WORD_PRI + k) begin
        for (int j = 0; j < SRC_PER_PRI; j++)
          bus_rdata[4*j +: 4] = {1'b0, prio_q[k*SRC_PER_PRI+j]};
      end
    end
    if (int'(word) == WORD_CTL)  bus_rdata = {31'b0, ctl_q};
    if (int'(word) == WORD_BASE) bus_rdata = base_q;
    if (int'(word) == WORD_ENT)
      bus_rdata = win_valid ? base_q + {{(30-IDX_W){1'b0}}, win_idx, 2'b00} : '0;
  end

  assign en         = en_q;
  assign prio       = prio_q;
  assign scope_norm = ctl_q;
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int                 NUM_SRC  = 64,  // at most 64: two banks
  parameter int                 ADDR_W   = 8,
  parameter logic [NUM_SRC-1:0] EDGE_SEL = {{(NUM_SRC/2){1'b0}}, {(NUM_SRC/2){1'b1}}},
  localparam int                IDX_W    = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               arst_n,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] src_in,
  output logic               irq_fast,
  output logic               irq_norm
);
  logic                rst_meta_q, rst_sync_n;
  logic [NUM_SRC-1:0]  pend, en, clr, fast_rt, live, arb_req;
  prio_t [NUM_SRC-1:0] prio;
  logic                scope_norm, arb_valid;
  logic [IDX_W-1:0]    arb_idx;
  prio_t               arb_prio;

  // Reset: asserted at once, released on the second clock edge.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  intc_pending #(.NUM_SRC(NUM_SRC), .EDGE_SEL(EDGE_SEL)) u_pend (
    .clk(clk), .rst_n(rst_sync_n), .src_in(src_in), .clr(clr), .pend(pend)
  );

  intc_regbank #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pend(pend), .fast_rt(fast_rt),
    .win_valid(arb_valid), .win_idx(arb_idx), .en(en), .prio(prio), .clr(clr),
    .scope_norm(scope_norm)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_rt
    assign fast_rt[i] = (prio[i][PRIO_W-1:1] == '0);
  end

  assign live     = pend & en;
  assign arb_req  = scope_norm ? (live & ~fast_rt) : live;
  assign irq_fast = |(live & fast_rt);
  assign irq_norm = |(live & ~fast_rt);

  intc_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .req(arb_req), .prio(prio), .win_valid(arb_valid), .win_idx(arb_idx),
    .win_prio(arb_prio)
  );
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int                 NUM_SRC  = 64,
  parameter int                 ADDR_W   = 8,
  parameter logic [NUM_SRC-1:0] EDGE_SEL = '1,
  localparam int                IDX_W    = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [31:0]        bus_wdata,
  input logic [NUM_SRC-1:0] src_in,
  input logic [NUM_SRC-1:0] pend,
  input logic [NUM_SRC-1:0] en,
  input logic               scope_norm,
  input logic               arb_valid,
  input logic [IDX_W-1:0]   arb_idx,
  input logic [2:0]         arb_prio,
  input logic               irq_fast,
  input logic               irq_norm
);
  logic [ADDR_W-3:0] word;
  assign word = bus_addr[ADDR_W-1:2];

  // R2
  edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (EDGE_SEL[0] && $rose(src_in[0])) |=> pend[0]);

  // R3
  level_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!EDGE_SEL[NUM_SRC-1] && src_in[NUM_SRC-1]) |=> pend[NUM_SRC-1]);

  // R4
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && word == '0 && bus_wdata[1] && !src_in[1]) |=> !pend[1]);

  // R6
  pend_retain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[0] && !(bus_we && (int'(word) == 0 || int'(word) == 2))) |=> pend[0]);

  // R8
  fast_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scope_norm && irq_fast) |-> (arb_valid && arb_prio < 3'd2));

  // R8
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scope_norm && !arb_valid) |-> (!irq_fast && !irq_norm));

  // R9
  winner_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_valid |-> (pend[arb_idx] && en[arb_idx]));
endmodule

bind prio_intc intc_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .EDGE_SEL(EDGE_SEL)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .src_in(src_in), .pend(pend), .en(en),
  .scope_norm(scope_norm), .arb_valid(arb_valid), .arb_idx(arb_idx),
  .arb_prio(arb_prio), .irq_fast(irq_fast), .irq_norm(irq_norm)
);

// File: tb/prio_intc_bench.sv
module prio_intc_bench;
  logic        clk = 1'b0;
  logic        arst_n;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [63:0] src_in;
  logic        irq_fast, irq_norm;
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 1'b0;
  logic [31:0] rv;

  always #10 clk = ~clk;  // 50 MHz

  prio_intc u_prio_intc (
    .clk(clk), .arst_n(arst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
    .irq_fast(irq_fast), .irq_norm(irq_norm)
  );

  // {write addr, write data, read addr, expected}
  localparam int NVEC = 10;
  localparam logic [79:0] VEC [NVEC] = '{
    {8'h30, 32'h1234_5670, 8'h30, 32'h1234_5670},
    {8'h34, 32'hFFFF_FFFF, 8'h34, 32'h7777_7777},
    {8'h4C, 32'h0123_4567, 8'h4C, 32'h0123_4567},
    {8'h18, 32'hA5A5_A5A5, 8'h18, 32'hA5A5_A5A5},
    {8'h1C, 32'h0000_FFFF, 8'h1C, 32'h0000_FFFF},
    {8'h24, 32'hDEAD_BEE0, 8'h24, 32'hDEAD_BEE0},
    {8'h20, 32'hFFFF_FFFF, 8'h20, 32'h0000_0001},
    {8'h20, 32'h0000_0000, 8'h20, 32'h0000_0000},
    {8'h44, 32'h7654_3210, 8'h44, 32'h7654_3210},
    {8'h38, 32'h1111_1111, 8'h34, 32'h7777_7777}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic drive_src(input int i, input logic v);
    @(negedge clk);
    src_in[i] = v;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    arst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; src_in = '0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    arst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; src_in = '0;
    do_reset();

    // R1 reset state
    rd(8'h18, rv); chk("R1 enable0", rv, 32'h0);
    rd(8'h1C, rv); chk("R1 enable1", rv, 32'h0);
    rd(8'h30, rv); chk("R1 prio0", rv, 32'h7777_7777);
    rd(8'h4C, rv); chk("R1 prio7", rv, 32'h7777_7777);
    rd(8'h0C, rv); chk("R1 status", rv, 32'h0);
    rd(8'h28, rv); chk("R1 entry", rv, 32'h0);
    rd(8'h24, rv); chk("R1 base", rv, 32'h0);
    chk("R1 lines", {30'b0, irq_fast, irq_norm}, 32'h0);

    // Register table (R6 R7 R10 R11)
    for (int n = 0; n < NVEC; n++) begin
      wr(VEC[n][79:72], VEC[n][71:40]);
      rd(VEC[n][39:32], rv);
      chk($sformatf("R7 R6 R10 R11 row %0d", n), rv, VEC[n][31:0]);
    end

    do_reset();
    wr(8'h24, 32'h0000_1000);
    wr(8'h30, 32'h7777_1777);        // source 3 -> priority 1
    wr(8'h18, 32'h0000_0008);
    drive_src(3, 1'b1);
    rd(8'h00, rv); chk("R2 R5 edge sets fast status", rv, 32'h8);
    rd(8'h08, rv); chk("R5 not in normal status", rv, 32'h0);
    chk("R8 fast line", {30'b0, irq_fast, irq_norm}, 32'h2);
    rd(8'h28, rv); chk("R9 entry src3", rv, 32'h0000_100C);
    wr(8'h00, 32'h0);
    rd(8'h00, rv); chk("R4 zero write no effect", rv, 32'h8);
    wr(8'h08, 32'h8);
    rd(8'h00, rv); chk("R4 clear via other status word", rv, 32'h0);
    repeat (2) @(negedge clk);
    rd(8'h00, rv); chk("R2 held high no reset", rv, 32'h0);
    rd(8'h28, rv); chk("R9 entry idle", rv, 32'h0);
    chk("R8 lines idle", {30'b0, irq_fast, irq_norm}, 32'h0);
    drive_src(3, 1'b0);
    drive_src(3, 1'b1);
    rd(8'h00, rv); chk("R2 second edge", rv, 32'h8);

    // Level source 40, priority 5
    wr(8'h44, 32'h7777_7775);
    wr(8'h1C, 32'h0000_0100);
    drive_src(40, 1'b1);
    rd(8'h0C, rv); chk("R3 R5 level sets bank1 bit8", rv, 32'h100);
    rd(8'h04, rv); chk("R5 level not fast", rv, 32'h0);
    chk("R8 both lines", {30'b0, irq_fast, irq_norm}, 32'h3);
    rd(8'h28, rv); chk("R9 fast prio wins", rv, 32'h0000_100C);
    wr(8'h0C, 32'h100);
    rd(8'h0C, rv); chk("R3 clear while high", rv, 32'h100);
    drive_src(40, 1'b0);
    wr(8'h0C, 32'h100);
    rd(8'h0C, rv); chk("R3 clear when low", rv, 32'h0);

    // Arbitration: 5 and 9 at prio 4, 40 at prio 3
    drive_src(3, 1'b0);
    wr(8'h00, 32'h8);
    wr(8'h30, 32'h7747_7777);
    wr(8'h34, 32'h7777_7747);
    wr(8'h44, 32'h7777_7773);
    wr(8'h18, 32'h0000_0220);
    @(negedge clk);
    src_in[5] = 1'b1; src_in[9] = 1'b1; src_in[40] = 1'b1;
    @(negedge clk);
    rd(8'h28, rv); chk("R9 lowest value wins", rv, 32'h0000_10A0);
    src_in[5] = 1'b0; src_in[9] = 1'b0; src_in[40] = 1'b0;
    wr(8'h0C, 32'h100);
    rd(8'h28, rv); chk("R9 tie lower number", rv, 32'h0000_1014);
    rd(8'h08, rv); chk("R5 two normal flags", rv, 32'h220);

    // Masking
    wr(8'h18, 32'h0000_0200);
    rd(8'h28, rv); chk("R6 masked skipped", rv, 32'h0000_1024);
    rd(8'h08, rv); chk("R6 flag kept", rv, 32'h220);
    wr(8'h18, 32'h0);
    rd(8'h28, rv); chk("R6 all masked entry", rv, 32'h0);
    chk("R6 R8 all masked lines", {30'b0, irq_fast, irq_norm}, 32'h0);
    wr(8'h18, 32'h0000_0220);
    rd(8'h28, rv); chk("R6 re-enabled", rv, 32'h0000_1014);

    // Entry scope control
    wr(8'h30, 32'h7747_1777);
    wr(8'h18, 32'h0000_0228);
    drive_src(3, 1'b1);
    rd(8'h28, rv); chk("R10 scope all", rv, 32'h0000_100C);
    wr(8'h20, 32'h1);
    rd(8'h28, rv); chk("R10 scope normal only", rv, 32'h0000_1014);
    chk("R10 lines unaffected", {30'b0, irq_fast, irq_norm}, 32'h3);
    rd(8'h20, rv); chk("R10 readback", rv, 32'h1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule